// File: doc/BRIEF.md
# Sampled Edge Phase Frequency Detector

This block compares a reference clock with the divided-down oscillator clock of a digital clock-generation loop. It runs on a fast sampling clock and treats both of those clocks as ordinary data inputs. Each input is synchronized and then searched for rising edges. A rising edge on the reference sets a "speed up" flop. A rising edge on the feedback sets a "slow down" flop. Whenever the two flops would both be high, a clearing term resets them together, so only the edge that leads shows up as a pulse. The length of that pulse, in sampling cycles, measures the phase error.

Next to the up and down pulses, the block provides two flags for a counter-based control-word generator. The mismatch flag is high whenever a phase error is being reported. The direction flag tells which way the oscillator must move, and it keeps its last value while no error is present. Together the two flags form the count-up and count-down enables of the next stage.

Top module: `pfd_edge_detector`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, up, down, event_out and direction are all 0.
- R2: A 0-to-1 change on ref_in that is present at sampling edge k makes up go high after sampling edge k+2 (three registers: two synchronizer stages and the capture flop), provided no feedback edge is detected in that cycle and down is low.
- R3: A 0-to-1 change on fb_in makes down go high with the same latency of edge k+2, provided no reference edge is detected in that cycle and up is low.
- R4: When a rising edge on the opposite input is detected while up or down is high, both flops clear in that same capture cycle.
- R5: Rising edges on ref_in and fb_in that are sampled at the same sampling edge assert neither up nor down, and event_out stays 0.
- R6: up and down are never high in the same cycle.
- R7: event_out is 1 exactly when up or down is high, and 0 otherwise.
- R8: direction is 1 while up is high and 0 while down is high. While both are low, it keeps the value it had in the previous cycle.
- R9: Falling edges and steady levels on ref_in and fb_in set neither flop. A detected edge lasts exactly one sampling cycle.
- R10: More rising edges on the same input while its flop is already set leave that flop set. They do not toggle it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, sampled as data |
| fb_in | input | 1 | Divided oscillator clock, sampled as data |
| up | output | 1 | Oscillator must speed up (reference leads) |
| down | output | 1 | Oscillator must slow down (feedback leads) |
| event_out | output | 1 | A phase mismatch is being reported |
| direction | output | 1 | 1 = count up, 0 = count down; holds while no mismatch |

## Verification
Some properties are checked on every cycle by the assertions:
- up and down never overlap.
- A detected edge sets its own flop, or clears both when the opposite flop is set or both edges coincide.
- A set flop stays set until the other edge arrives.
- Edge pulses last one cycle.
- direction follows up and holds when the mismatch flag falls.

Other properties can only be shown by the bench scenarios, which compare every cycle against a behavioural model:
- the exact three-cycle latency from an input change to up or down;
- that falling edges are ignored;
- the coincident-edge case seen at the ports;
- the value direction keeps after a long idle stretch.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Pair of phase-error flops: lead of reference (up) or feedback (dn)
    typedef struct packed {
        logic up;
        logic dn;
    } pfd_pair_t;

    // Minimum synchronizer depth accepted by the edge stage
    localparam int PFD_MIN_SYNC = 2;

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise_o
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], din};
        st_d.prev = st_q.sh[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.sh[LAST] & ~st_q.prev;

    // R9: an edge report is a single-cycle pulse
    p_edge_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pfd_capture.sv
module pfd_capture
    import pfd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ref_rise,
    input  logic      fb_rise,
    output pfd_pair_t pair_o
);
    pfd_pair_t pair_d, pair_q;
    pfd_pair_t set_w;

    always_comb begin
        set_w.up = pair_q.up | ref_rise;
        set_w.dn = pair_q.dn | fb_rise;
        pair_d   = set_w;
        if (set_w.up && set_w.dn) begin
            pair_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pair_q <= '0;
        else        pair_q <= pair_d;
    end

    assign pair_o = pair_q;

    p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(pair_q.up && pair_q.dn));

    p_set_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_rise && !fb_rise && !pair_q.dn) |=> pair_q.up);

    p_set_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_rise && !ref_rise && !pair_q.up) |=> pair_q.dn);

    p_clear_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_q.up && fb_rise) |=> (!pair_q.up && !pair_q.dn));

    p_clear_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_q.dn && ref_rise) |=> (!pair_q.up && !pair_q.dn));

    p_coincide_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_rise && fb_rise) |=> (!pair_q.up && !pair_q.dn));

    p_hold_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_q.up && !fb_rise) |=> pair_q.up);

    p_hold_dn_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_q.dn && !ref_rise) |=> pair_q.dn);

endmodule

// File: rtl/pfd_flags.sv
module pfd_flags
    import pfd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pfd_pair_t pair_i,
    output logic      event_o,
    output logic      dir_o
);
    typedef struct packed {
        logic dir;
    } flag_state_t;

    flag_state_t fl_d, fl_q;
    logic        dir_w;

    always_comb begin
        if (pair_i.up)      dir_w = 1'b1;
        else if (pair_i.dn) dir_w = 1'b0;
        else                dir_w = fl_q.dir;
        fl_d.dir = dir_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign event_o = pair_i.up | pair_i.dn;
    assign dir_o   = dir_w;

    p_dir_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pair_i.up |-> dir_o);

    p_dir_dn_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pair_i.dn |-> !dir_o);

    p_dir_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(event_o) |-> $stable(dir_o));

endmodule

// File: rtl/pfd_edge_detector.sv
module pfd_edge_detector
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    output logic up,
    output logic down,
    output logic event_out,
    output logic direction
);
    logic      ref_rise;
    logic      fb_rise;
    pfd_pair_t pair;

    initial begin
        if (SYNC_STAGES < PFD_MIN_SYNC)
            $error("SYNC_STAGES below minimum");
    end

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (ref_in),
        .rise_o (ref_rise)
    );

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_fb (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (fb_in),
        .rise_o (fb_rise)
    );

    pfd_capture u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_rise (ref_rise),
        .fb_rise  (fb_rise),
        .pair_o   (pair)
    );

    pfd_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .pair_i  (pair),
        .event_o (event_out),
        .dir_o   (direction)
    );

    assign up   = pair.up;
    assign down = pair.dn;

endmodule

// File: tb/pfd_edge_detector_bench.sv
module pfd_edge_detector_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic up, down, event_out, direction;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic [2:0] rh = '0, fh = '0;
    logic m_up = 0, m_dn = 0, m_dir = 0, m_hold = 0;

    always #5 clk = ~clk;

    pfd_edge_detector u_pfd_edge_detector (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .up(up), .down(down), .event_out(event_out), .direction(direction)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rh = '0; fh = '0;
            m_up = 0; m_dn = 0; m_dir = 0; m_hold = 0;
        end else begin
            logic re, fe, nu, nd;
            re = rh[1] & ~rh[2];
            fe = fh[1] & ~fh[2];
            m_hold = m_dir;
            nu = m_up | re;
            nd = m_dn | fe;
            if (nu && nd) begin nu = 0; nd = 0; end
            m_up = nu; m_dn = nd;
            m_dir = m_up ? 1'b1 : (m_dn ? 1'b0 : m_hold);
            rh = {rh[1:0], ref_in};
            fh = {fh[1:0], fb_in};
        end
    end

    always @(negedge clk) begin
        cycles++;
        checks++;
        if (up !== m_up || down !== m_dn || direction !== m_dir) begin
            errors++;
            $display("FAIL %s up/down/dir=%b%b%b expected %b%b%b",
                     cur_req, up, down, direction, m_up, m_dn, m_dir);
        end
        checks++;
        if (up === 1'b1 && down === 1'b1) begin
            errors++;
            $display("FAIL R6 up/down=%b%b expected not both 1", up, down);
        end
        checks++;
        if (event_out !== (up | down)) begin
            errors++;
            $display("FAIL R7 event_out=%b expected %b", event_out, up | down);
        end
        if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog cycles=%0d expected <200000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic eu, input logic ed,
                              input logic ev, input logic edir);
        checks++;
        if (up !== eu || down !== ed || event_out !== ev || direction !== edir) begin
            errors++;
            $display("FAIL %s u/d/e/dir=%b%b%b%b expected %b%b%b%b",
                     req, up, down, event_out, direction, eu, ed, ev, edir);
        end
    endtask

    initial begin
        cur_req = "R1";
        tick(2);
        expect_out("R1", 0, 0, 0, 0);
        tick(2);
        rst_n = 1'b1;
        tick(1);
        expect_out("R1", 0, 0, 0, 0);

        // R2: ref rise, up after three sampling edges
        cur_req = "R2";
        ref_in = 1;
        tick(2);
        expect_out("R2", 0, 0, 0, 0);
        tick(1);
        expect_out("R2", 1, 0, 1, 1);
        // R9: falling ref edge does nothing
        cur_req = "R9";
        ref_in = 0;
        tick(5);
        expect_out("R9", 1, 0, 1, 1);
        // R10: another ref edge while up set
        cur_req = "R10";
        ref_in = 1; tick(2); ref_in = 0; tick(5);
        expect_out("R10", 1, 0, 1, 1);
        // R4: fb edge clears both
        cur_req = "R4";
        fb_in = 1;
        tick(3);
        expect_out("R4", 0, 0, 0, 1);
        // R8: direction holds while idle
        cur_req = "R8";
        fb_in = 0;
        tick(10);
        expect_out("R8", 0, 0, 0, 1);

        // R3: fb leads
        cur_req = "R3";
        fb_in = 1;
        tick(3);
        expect_out("R3", 0, 1, 1, 0);
        fb_in = 0; tick(4);
        cur_req = "R4";
        ref_in = 1;
        tick(3);
        expect_out("R4", 0, 0, 0, 0);
        ref_in = 0; tick(6);
        expect_out("R8", 0, 0, 0, 0);

        // R5: simultaneous edges
        cur_req = "R5";
        ref_in = 1; fb_in = 1;
        for (int i = 0; i < 6; i++) begin
            tick(1);
            expect_out("R5", 0, 0, 0, 0);
        end
        ref_in = 0; fb_in = 0;
        tick(6);
        expect_out("R9", 0, 0, 0, 0);

        // R6/R7/R8 under pseudo-random clocks of differing rates
        cur_req = "R6";
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 6) == 0) ref_in = ~ref_in;
            if ($urandom_range(0, 7) == 0) fb_in = ~fb_in;
            tick(1);
        end
        // periodic clocks with slowly shifting phase
        cur_req = "R8";
        for (int p = 0; p < 40; p++) begin
            for (int i = 0; i < 16; i++) begin
                ref_in = (i < 8);
                fb_in  = (((i + p) % 16) < 8);
                tick(1);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule